// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a processor subsystem leaves active operation for a light sleep or a deep sleep, and how it comes back. When the processor signals a wait-for-interrupt event, the block looks at a programmed power-mode field and at the processor's deep-sleep flag. It then either gates only the processor clock (light sleep), gates every clock and forces the analog power-down enables (deep sleep), or ignores the event. Light sleep ends when an enabled interrupt is pending. Deep sleep ends only on a qualified pin interrupt, or on a brown-out event when the brown-out detector was programmed to stay powered.

Deep-sleep exit is done in steps. The analog power enables are first loaded from a wake-up configuration word. A programmable settling count then elapses, and only after that are the clocks re-enabled and the processor released. A status word records the last mode entered and the source that ended it. Software clears it by writing ones. All configuration words sit behind a simple single-cycle register write port, with a combinational read port beside it. The block has no streamed data path: every pin is a plain control or status level, and writes are always accepted with no back-pressure.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: After reset the block is active. The processor, main, peripheral and watchdog clocks are enabled, the oscillator output is enabled and flash is not in standby. `pd_out` equals the run configuration reset value (0), and the status and mode registers read 0.
- R2: With mode field (address 0) equal to 0, a `wfi` pulse drops `cpu_clk_en` in the next cycle. The main and peripheral clocks and `pd_out` stay unchanged. The state is left only when `irq_pending` is high; pin and brown-out inputs have no effect there.
- R3: Deep sleep is entered only when the mode field equals 1, `deep_flag` is high and `wfi` is high. A `wfi` with mode 1 and `deep_flag` low, or with mode 2..7, leaves the block active.
- R4: In deep sleep and during settling, the processor, main and peripheral clocks are off, `fro_out_en` is 0 and `flash_standby` is 1. `wdt_clk_en` equals the inverse of deep-sleep configuration bit 6 (0 keeps the watchdog oscillator on).
- R5: In deep sleep every `pd_out` bit is 1, except bit 3 (brown-out) and bit 6 (watchdog oscillator), which copy the same bits of the deep-sleep configuration word (address 1).
- R6: In deep sleep, pin i wakes the block only when `pin_irq[i]`, `pin_en[i]` and start-mask bit i (address 4) are all high. `irq_pending` does not wake it.
- R7: `bod_det` wakes the block from deep sleep only when deep-sleep configuration bit 3 is 0.
- R8: From the cycle after a deep-sleep wake, `pd_out` equals the wake configuration word (address 2), and that value is copied into the run configuration register (address 3).
- R9: After a deep-sleep wake the clocks stay off for N+1 cycles, where N is the settle count (address 5). The block is then active with all clocks on.
- R10: The status word (address 6) has bit 0 set when light sleep was last entered and bit 1 when deep sleep was. Bit 2 means woken by interrupt, bit 3 by brown-out, and bits 4+i by pin i. Writing ones clears bits, and a hardware update in the same cycle wins.
- R11: An asynchronous reset while in a low-power state restores the R1 state and all register defaults.
- R12: Registers read back what was written: mode (3 bits), deep-sleep, wake and run configuration (8 bits each), start mask (8 bits) and settle count (8 bits). The deep-sleep word resets to 0xFF and the settle count to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| wfi | input | 1 | Processor wait-for-interrupt event |
| deep_flag | input | 1 | Processor deep-sleep request flag |
| irq_pending | input | 1 | An enabled interrupt is pending at the processor |
| pin_irq | input | 8 | Pin interrupt lines |
| pin_en | input | 8 | Per-pin interrupt enables |
| bod_det | input | 1 | Brown-out detect |
| cpu_clk_en | output | 1 | Processor clock enable |
| main_clk_en | output | 1 | Main clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| wdt_clk_en | output | 1 | Watchdog timer clock enable |
| fro_out_en | output | 1 | Internal RC oscillator output enable |
| flash_standby | output | 1 | Flash standby request |
| pd_out | output | 8 | Analog power-down enables (1 = powered down) |

## Verification
Every mode change and every wake is registered once. Clock and power outputs therefore move one cycle after the cycle that sampled `wfi`, `irq_pending`, a pin or `bod_det`, and a write is visible on the read port one cycle after its strobe. A deep-sleep wake holds the clocks off for settle+1 further cycles before the active state returns. The bench drives inputs on the falling edge and compares every output against a behavioural model on the following falling edge, so each result is sampled in exactly the cycle it is due. Directed checks count settling cycles one by one and read registers a fraction of a cycle after setting the read address.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LPM_RUN    = 2'd0,
    LPM_NAP    = 2'd1,
    LPM_DEEP   = 2'd2,
    LPM_SETTLE = 2'd3
  } lpm_state_e;

  localparam logic [2:0] A_PMODE     = 3'd0;
  localparam logic [2:0] A_DSCFG     = 3'd1;
  localparam logic [2:0] A_WAKECFG   = 3'd2;
  localparam logic [2:0] A_RUNCFG    = 3'd3;
  localparam logic [2:0] A_STARTMASK = 3'd4;
  localparam logic [2:0] A_SETTLE    = 3'd5;
  localparam logic [2:0] A_STATUS    = 3'd6;

  localparam logic [2:0] PM_NAP  = 3'd0;
  localparam logic [2:0] PM_DEEP = 3'd1;
endpackage

// File: rtl/lpm_cfg_regs.sv
module lpm_cfg_regs
  import lpm_pkg::*;
#(
  parameter int PD_W     = 8,
  parameter int NPIN     = 8,
  parameter int SETTLE_W = 8,
  parameter int DATA_W   = 16,
  parameter logic [PD_W-1:0]     RUN_RST    = '0,
  parameter logic [PD_W-1:0]     WAKE_RST   = '0,
  parameter logic [SETTLE_W-1:0] SETTLE_RST = 4,
  localparam int SRC_W  = NPIN + 2,
  localparam int STAT_W = SRC_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [2:0]          rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                ev_mode_we,
  input  logic [1:0]          ev_mode,
  input  logic                ev_src_we,
  input  logic [SRC_W-1:0]    ev_src,
  input  logic                wake_load,
  output logic [2:0]          pmode,
  output logic [PD_W-1:0]     ds_cfg,
  output logic [PD_W-1:0]     wake_cfg,
  output logic [PD_W-1:0]     run_cfg,
  output logic [NPIN-1:0]     start_mask,
  output logic [SETTLE_W-1:0] settle
);
  logic [STAT_W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmode      <= PM_NAP;
      ds_cfg     <= '1;
      wake_cfg   <= WAKE_RST;
      run_cfg    <= RUN_RST;
      start_mask <= '0;
      settle     <= SETTLE_RST;
      stat_q     <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_PMODE:     pmode      <= wr_data[2:0];
          A_DSCFG:     ds_cfg     <= wr_data[PD_W-1:0];
          A_WAKECFG:   wake_cfg   <= wr_data[PD_W-1:0];
          A_RUNCFG:    run_cfg    <= wr_data[PD_W-1:0];
          A_STARTMASK: start_mask <= wr_data[NPIN-1:0];
          A_SETTLE:    settle     <= wr_data[SETTLE_W-1:0];
          A_STATUS:    stat_q     <= stat_q & ~wr_data[STAT_W-1:0];
          default: ;
        endcase
      end
      // hardware updates follow software so they take precedence
      if (wake_load) run_cfg <= wake_cfg;
      if (ev_mode_we) stat_q[1:0] <= ev_mode;
      if (ev_src_we) stat_q[STAT_W-1:2] <= ev_src;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_PMODE:     rd_data[2:0]          = pmode;
      A_DSCFG:     rd_data[PD_W-1:0]     = ds_cfg;
      A_WAKECFG:   rd_data[PD_W-1:0]     = wake_cfg;
      A_RUNCFG:    rd_data[PD_W-1:0]     = run_cfg;
      A_STARTMASK: rd_data[NPIN-1:0]     = start_mask;
      A_SETTLE:    rd_data[SETTLE_W-1:0] = settle;
      A_STATUS:    rd_data[STAT_W-1:0]   = stat_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int NPIN = 8
) (
  input  logic [NPIN-1:0] pin_irq,
  input  logic [NPIN-1:0] pin_en,
  input  logic [NPIN-1:0] start_mask,
  input  logic            bod_det,
  input  logic            bod_kept,
  output logic [NPIN-1:0] pin_hits,
  output logic            bod_hit,
  output logic            wake_any
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign pin_hits[i] = pin_irq[i] & pin_en[i] & start_mask[i];
  end

  assign bod_hit  = bod_det & bod_kept;
  assign wake_any = (|pin_hits) | bod_hit;
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wfi,
  input  logic                deep_flag,
  input  logic [2:0]          pmode,
  input  logic                irq_pending,
  input  logic                wake_any,
  input  logic [SETTLE_W-1:0] settle,
  output lpm_state_e          st,
  output logic                ev_nap_in,
  output logic                ev_deep_in,
  output logic                ev_nap_out,
  output logic                ev_deep_out
);
  lpm_state_e          st_nx;
  logic [SETTLE_W-1:0] cnt_q;

  always_comb begin
    st_nx       = st;
    ev_nap_in   = 1'b0;
    ev_deep_in  = 1'b0;
    ev_nap_out  = 1'b0;
    ev_deep_out = 1'b0;
    case (st)
      LPM_RUN: begin
        if (wfi && pmode == PM_NAP) begin
          st_nx     = LPM_NAP;
          ev_nap_in = 1'b1;
        end else if (wfi && pmode == PM_DEEP && deep_flag) begin
          st_nx      = LPM_DEEP;
          ev_deep_in = 1'b1;
        end
      end
      LPM_NAP: begin
        if (irq_pending) begin
          st_nx      = LPM_RUN;
          ev_nap_out = 1'b1;
        end
      end
      LPM_DEEP: begin
        if (wake_any) begin
          st_nx       = LPM_SETTLE;
          ev_deep_out = 1'b1;
        end
      end
      LPM_SETTLE: begin
        if (cnt_q == '0) st_nx = LPM_RUN;
      end
      default: st_nx = LPM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= LPM_RUN;
      cnt_q <= '0;
    end else begin
      st <= st_nx;
      if (ev_deep_out) cnt_q <= settle;
      else if (st == LPM_SETTLE && cnt_q != '0) cnt_q <= cnt_q - SETTLE_W'(1);
    end
  end
endmodule

// File: rtl/lpm_out_decode.sv
module lpm_out_decode
  import lpm_pkg::*;
#(
  parameter int PD_W      = 8,
  parameter int BOD_BIT   = 3,
  parameter int WDOSC_BIT = 6
) (
  input  lpm_state_e      st,
  input  logic            ds_bod,
  input  logic            ds_wdosc,
  input  logic [PD_W-1:0] run_cfg,
  output logic            cpu_clk_en,
  output logic            main_clk_en,
  output logic            periph_clk_en,
  output logic            wdt_clk_en,
  output logic            fro_out_en,
  output logic            flash_standby,
  output logic [PD_W-1:0] pd_out
);
  logic            dark;
  logic [PD_W-1:0] deep_vec;

  for (genvar b = 0; b < PD_W; b++) begin : g_pd
    if (b == BOD_BIT) begin : g_bod
      assign deep_vec[b] = ds_bod;
    end else if (b == WDOSC_BIT) begin : g_wdosc
      assign deep_vec[b] = ds_wdosc;
    end else begin : g_off
      assign deep_vec[b] = 1'b1;
    end
  end

  assign dark          = (st == LPM_DEEP) || (st == LPM_SETTLE);
  assign cpu_clk_en    = (st == LPM_RUN);
  assign main_clk_en   = !dark;
  assign periph_clk_en = !dark;
  assign wdt_clk_en    = dark ? !ds_wdosc : 1'b1;
  assign fro_out_en    = !dark;
  assign flash_standby = dark;
  assign pd_out        = (st == LPM_DEEP) ? deep_vec : run_cfg;
endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
  import lpm_pkg::*;
#(
  parameter int NPIN      = 8,
  parameter int PD_W      = 8,
  parameter int SETTLE_W  = 8,
  parameter int DATA_W    = 16,
  parameter int BOD_BIT   = 3,
  parameter int WDOSC_BIT = 6,
  parameter logic [PD_W-1:0]     RUN_RST    = '0,
  parameter logic [PD_W-1:0]     WAKE_RST   = '0,
  parameter logic [SETTLE_W-1:0] SETTLE_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wfi,
  input  logic              deep_flag,
  input  logic              irq_pending,
  input  logic [NPIN-1:0]   pin_irq,
  input  logic [NPIN-1:0]   pin_en,
  input  logic              bod_det,
  output logic              cpu_clk_en,
  output logic              main_clk_en,
  output logic              periph_clk_en,
  output logic              wdt_clk_en,
  output logic              fro_out_en,
  output logic              flash_standby,
  output logic [PD_W-1:0]   pd_out
);
  localparam int SRC_W = NPIN + 2;

  lpm_state_e          st;
  logic [2:0]          pmode;
  logic [PD_W-1:0]     ds_cfg, wake_cfg, run_cfg;
  logic [NPIN-1:0]     start_mask, pin_hits;
  logic [SETTLE_W-1:0] settle;
  logic                bod_hit, wake_any;
  logic                ev_nap_in, ev_deep_in, ev_nap_out, ev_deep_out;
  logic [1:0]          ev_mode;
  logic [SRC_W-1:0]    ev_src;

  assign ev_mode = ev_deep_in ? 2'b10 : 2'b01;
  assign ev_src  = ev_nap_out ? SRC_W'(1) : {pin_hits, bod_hit, 1'b0};

  lpm_cfg_regs #(
    .PD_W(PD_W), .NPIN(NPIN), .SETTLE_W(SETTLE_W), .DATA_W(DATA_W),
    .RUN_RST(RUN_RST), .WAKE_RST(WAKE_RST), .SETTLE_RST(SETTLE_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_mode_we(ev_nap_in | ev_deep_in), .ev_mode(ev_mode),
    .ev_src_we(ev_nap_out | ev_deep_out), .ev_src(ev_src),
    .wake_load(ev_deep_out),
    .pmode(pmode), .ds_cfg(ds_cfg), .wake_cfg(wake_cfg), .run_cfg(run_cfg),
    .start_mask(start_mask), .settle(settle)
  );

  lpm_wake_qual #(.NPIN(NPIN)) u_wake (
    .pin_irq(pin_irq), .pin_en(pin_en), .start_mask(start_mask),
    .bod_det(bod_det), .bod_kept(!ds_cfg[BOD_BIT]),
    .pin_hits(pin_hits), .bod_hit(bod_hit), .wake_any(wake_any)
  );

  lpm_mode_fsm #(.SETTLE_W(SETTLE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wfi(wfi), .deep_flag(deep_flag),
    .pmode(pmode), .irq_pending(irq_pending), .wake_any(wake_any),
    .settle(settle), .st(st),
    .ev_nap_in(ev_nap_in), .ev_deep_in(ev_deep_in),
    .ev_nap_out(ev_nap_out), .ev_deep_out(ev_deep_out)
  );

  lpm_out_decode #(.PD_W(PD_W), .BOD_BIT(BOD_BIT), .WDOSC_BIT(WDOSC_BIT)) u_out (
    .st(st), .ds_bod(ds_cfg[BOD_BIT]), .ds_wdosc(ds_cfg[WDOSC_BIT]),
    .run_cfg(run_cfg),
    .cpu_clk_en(cpu_clk_en), .main_clk_en(main_clk_en),
    .periph_clk_en(periph_clk_en), .wdt_clk_en(wdt_clk_en),
    .fro_out_en(fro_out_en), .flash_standby(flash_standby), .pd_out(pd_out)
  );
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker
  import lpm_pkg::*;
#(
  parameter int PD_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input lpm_state_e      st,
  input logic            wfi,
  input logic            deep_flag,
  input logic [2:0]      pmode,
  input logic            wr_en,
  input logic            ds_bod,
  input logic            ds_wdosc,
  input logic            bod_sel,
  input logic            wdosc_sel,
  input logic [PD_W-1:0] wake_cfg,
  input logic            pin_any,
  input logic            wake_any,
  input logic            cpu_clk_en,
  input logic            main_clk_en,
  input logic            fro_out_en,
  input logic            flash_standby,
  input logic [PD_W-1:0] pd_out
);
  // R2: power-down outputs hold while in light sleep absent writes
  a_r2_nap_pd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LPM_NAP && $past(st == LPM_NAP) && !$past(wr_en)) |-> $stable(pd_out));

  a_r3_deep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LPM_RUN && wfi && pmode == 3'd1 && deep_flag) |=> st == LPM_DEEP);

  a_r3_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LPM_RUN && wfi && pmode != 3'd0 && !(pmode == 3'd1 && deep_flag)) |=> st == LPM_RUN);

  a_r4_deep_gated: assert property (@(posedge clk) disable iff (!rst_n)
    flash_standby |-> (!cpu_clk_en && !main_clk_en && !fro_out_en));

  a_r5_deep_pd: assert property (@(posedge clk) disable iff (!rst_n)
    st == LPM_DEEP |-> (bod_sel == ds_bod && wdosc_sel == ds_wdosc && $countones(pd_out) >= PD_W - 2));

  a_r7_bod_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LPM_DEEP && ds_bod && !pin_any) |=> st == LPM_DEEP);

  a_r8_wake_load: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LPM_DEEP && wake_any) |=> pd_out == $past(wake_cfg));

  a_r9_settle_dark: assert property (@(posedge clk) disable iff (!rst_n)
    st == LPM_SETTLE |-> (!cpu_clk_en && !main_clk_en && flash_standby));
endmodule

bind lpm_seq_ctrl lpm_checker #(.PD_W(PD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .wfi(wfi), .deep_flag(deep_flag),
  .pmode(pmode), .wr_en(wr_en),
  .ds_bod(ds_cfg[BOD_BIT]), .ds_wdosc(ds_cfg[WDOSC_BIT]),
  .bod_sel(pd_out[BOD_BIT]), .wdosc_sel(pd_out[WDOSC_BIT]),
  .wake_cfg(wake_cfg), .pin_any(|pin_hits), .wake_any(wake_any),
  .cpu_clk_en(cpu_clk_en), .main_clk_en(main_clk_en),
  .fro_out_en(fro_out_en), .flash_standby(flash_standby), .pd_out(pd_out)
);

// File: tb/test_lpm_seq_ctrl.sv
`timescale 1ns/1ps
module test_lpm_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        wfi = 1'b0, deep_flag = 1'b0, irq_pending = 1'b0, bod_det = 1'b0;
  logic [7:0]  pin_irq = '0, pin_en = '0;
  logic        cpu_clk_en, main_clk_en, periph_clk_en, wdt_clk_en, fro_out_en, flash_standby;
  logic [7:0]  pd_out;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lpm_seq_ctrl i_lpm_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wfi(wfi), .deep_flag(deep_flag),
    .irq_pending(irq_pending), .pin_irq(pin_irq), .pin_en(pin_en), .bod_det(bod_det),
    .cpu_clk_en(cpu_clk_en), .main_clk_en(main_clk_en), .periph_clk_en(periph_clk_en),
    .wdt_clk_en(wdt_clk_en), .fro_out_en(fro_out_en), .flash_standby(flash_standby),
    .pd_out(pd_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: 0 active, 1 light sleep, 2 deep, 3 settling
  int         m_st, m_cnt;
  logic [2:0] m_pm;
  logic [7:0] m_ds, m_wk, m_run, m_mask, m_set;
  logic [11:0] m_stat;
  logic [7:0] o_ds, o_wk, o_mask, o_set, m_hits;
  logic [2:0] o_pm;
  logic       m_bw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_pm = 0; m_ds = 8'hFF; m_wk = 0; m_run = 0;
      m_mask = 0; m_set = 8'd4; m_stat = 0;
    end else begin
      o_pm = m_pm; o_ds = m_ds; o_wk = m_wk; o_mask = m_mask; o_set = m_set;
      m_hits = pin_irq & pin_en & o_mask;
      m_bw = bod_det && !o_ds[3];
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_pm = wr_data[2:0];
          3'd1: m_ds = wr_data[7:0];
          3'd2: m_wk = wr_data[7:0];
          3'd3: m_run = wr_data[7:0];
          3'd4: m_mask = wr_data[7:0];
          3'd5: m_set = wr_data[7:0];
          3'd6: m_stat = m_stat & ~wr_data[11:0];
          default: ;
        endcase
      end
      case (m_st)
        0: if (wfi && o_pm == 0) begin m_st = 1; m_stat[1:0] = 2'b01; end
           else if (wfi && o_pm == 1 && deep_flag) begin m_st = 2; m_stat[1:0] = 2'b10; end
        1: if (irq_pending) begin m_st = 0; m_stat[11:2] = 10'b1; end
        2: if ((m_hits != 0) || m_bw) begin
             m_st = 3; m_cnt = o_set; m_run = o_wk; m_stat[11:2] = {m_hits, m_bw, 1'b0};
           end
        default: if (m_cnt == 0) m_st = 0; else m_cnt = m_cnt - 1;
      endcase
    end
  end

  function automatic logic [13:0] model_out();
    logic dark = (m_st >= 2);
    logic [7:0] pd = m_run;
    if (m_st == 2) begin
      pd = 8'hFF; pd[3] = m_ds[3]; pd[6] = m_ds[6];
    end
    return {m_st == 0, !dark, !dark, dark ? !m_ds[6] : 1'b1, !dark, dark, pd};
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tag;
      tag = (m_st == 0) ? "R1" : (m_st == 1) ? "R2" : (m_st == 2) ? "R5" : "R9";
      chk(tag, {18'b0, cpu_clk_en, main_clk_en, periph_clk_en, wdt_clk_en,
                fro_out_en, flash_standby, pd_out}, {18'b0, model_out()});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic pulse_wfi();
    @(negedge clk); wfi = 1;
    @(negedge clk); wfi = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cpu clk", cpu_clk_en, 1); chk("R1 main clk", main_clk_en, 1);
    chk("R1 flash", flash_standby, 0); chk("R1 pd_out", pd_out, 8'h00);
    rd(3'd6, d); chk("R1 status", d, 0);
    rd(3'd0, d); chk("R1 mode", d, 0);
    rd(3'd1, d); chk("R12 ds reset", d, 16'h00FF);
    rd(3'd5, d); chk("R12 settle reset", d, 4);

    wr(3'd3, 16'h0021); wr(3'd2, 16'h0005); wr(3'd1, 16'h0040);
    wr(3'd4, 16'h0024); wr(3'd5, 16'h0003);
    rd(3'd3, d); chk("R12 run", d, 16'h21);
    rd(3'd2, d); chk("R12 wake", d, 16'h05);
    rd(3'd1, d); chk("R12 ds", d, 16'h40);
    rd(3'd4, d); chk("R12 mask", d, 16'h24);
    rd(3'd5, d); chk("R12 settle", d, 16'h03);

    // light sleep
    pin_en = 8'hFF;
    pulse_wfi();
    chk("R2 cpu off", cpu_clk_en, 0); chk("R2 main on", main_clk_en, 1);
    chk("R2 pd held", pd_out, 8'h21);
    @(negedge clk); pin_irq = 8'h24; bod_det = 1;
    repeat (3) @(negedge clk);
    chk("R2 pins ignored", cpu_clk_en, 0);
    pin_irq = 0; bod_det = 0; irq_pending = 1;
    @(negedge clk); irq_pending = 0;
    chk("R2 irq wake", cpu_clk_en, 1); chk("R2 pd restored", pd_out, 8'h21);
    rd(3'd6, d); chk("R10 status nap", d, 16'h005);

    // no entry
    wr(3'd0, 16'h0001); deep_flag = 0;
    pulse_wfi(); chk("R3 flag low", cpu_clk_en, 1);
    wr(3'd0, 16'h0002); deep_flag = 1;
    pulse_wfi(); chk("R3 mode two", cpu_clk_en, 1);

    // deep sleep
    wr(3'd0, 16'h0001);
    pulse_wfi();
    chk("R4 flash", flash_standby, 1); chk("R4 main", main_clk_en, 0);
    chk("R4 periph", periph_clk_en, 0); chk("R4 fro", fro_out_en, 0);
    chk("R4 cpu", cpu_clk_en, 0); chk("R4 wdt off", wdt_clk_en, 0);
    chk("R5 pd deep", pd_out, 8'hF7);
    pin_irq = 8'h01; irq_pending = 1;
    repeat (2) @(negedge clk);
    chk("R6 unmasked pin/irq", flash_standby, 1);
    pin_irq = 8'h20; pin_en = 8'hDF; irq_pending = 0;
    repeat (2) @(negedge clk);
    chk("R6 disabled pin", flash_standby, 1);
    pin_en = 8'hFF;
    @(negedge clk); pin_irq = 0;
    chk("R8 pd wake", pd_out, 8'h05); chk("R9 settle dark", cpu_clk_en, 0);
    rd(3'd3, d); chk("R8 run copy", d, 16'h05);
    rd(3'd6, d); chk("R10 status pin5", d, 16'h202);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R9 still settling", main_clk_en, 0);
    end
    @(negedge clk);
    chk("R9 clocks back", cpu_clk_en, 1); chk("R9 main back", main_clk_en, 1);

    // brown-out masked
    wr(3'd1, 16'h0048);
    pulse_wfi(); chk("R5 pd all off", pd_out, 8'hFF);
    bod_det = 1; repeat (3) @(negedge clk);
    chk("R7 bod masked", flash_standby, 1);
    bod_det = 0; pin_irq = 8'h04;
    @(negedge clk); pin_irq = 0;
    repeat (6) @(negedge clk);
    chk("R9 back active", cpu_clk_en, 1);

    // brown-out enabled, watchdog oscillator kept
    wr(3'd1, 16'h0000);
    pulse_wfi();
    chk("R4 wdt kept", wdt_clk_en, 1); chk("R5 pd keep", pd_out, 8'hB7);
    bod_det = 1; @(negedge clk); bod_det = 0;
    chk("R7 bod wake", flash_standby, 1); chk("R7 cpu held", cpu_clk_en, 0);
    chk("R7 pd wake", pd_out, 8'h05);
    rd(3'd6, d); chk("R10 status bod", d, 16'h00A);
    repeat (6) @(negedge clk);
    wr(3'd6, 16'h0002); rd(3'd6, d); chk("R10 w1c part", d, 16'h008);
    wr(3'd6, 16'h0FFF); rd(3'd6, d); chk("R10 w1c all", d, 16'h000);

    // reset inside deep sleep
    pulse_wfi(); chk("R11 in deep", flash_standby, 1);
    @(negedge clk); rst_n = 0; #1;
    chk("R11 cpu", cpu_clk_en, 1); chk("R11 pd", pd_out, 8'h00);
    chk("R11 flash", flash_standby, 0);
    @(negedge clk); rst_n = 1;
    rd(3'd1, d); chk("R11 ds default", d, 16'h00FF);
    rd(3'd6, d); chk("R11 status", d, 0);
    rd(3'd0, d); chk("R11 mode", d, 0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule